// File: doc/BRIEF.md
# Register Scoreboard Stall Unit

This block tracks which general registers of a load/store processor still wait on a result from a long-latency pipeline. The register file holds 31 usable 32-bit registers, addressed by 5-bit indices 1 to 31. Index 0 is hard-wired and is never tracked. Each register has two pending bits. One marks an outstanding memory load. The other marks an outstanding floating-point write-back. Each bit is set by the instruction that creates the result and cleared by its own completion port.

The issue stage presents one instruction per cycle. It gives the source indices with their read enables, the destination with its write enable, and the instruction kind. The block answers in the same cycle with `stall`. Stall is high when the instruction reads or writes a register that is still pending. A completion arriving in that same cycle already counts as done. The issue port is a plain valid/stall handshake: an instruction is accepted in a cycle where `iss_valid` is high and `stall` is low. A stalled instruction must be held by the issue stage and has no effect on the block. Completion ports carry no back-pressure: a completion is consumed in the cycle its valid bit is high. Both pending vectors are outputs, so the whole scoreboard can be read at once.

Top module: `reg_scoreboard`

## Requirements
- R1: After reset, both pending vectors are all zero and `stall` is low.
- R2: An accepted instruction with `iss_wr_en`=1 and a nonzero destination sets that register's bit in `sb_load_pend` on the next cycle when `iss_kind`=1 (load), and sets it in `sb_fp_pend` when `iss_kind`=2 (floating point). Kind 0 (integer) and kind 3 set no bit.
- R3: `ld_done_valid` clears bit `ld_done_idx` of `sb_load_pend` on the next cycle. `fp_done_valid` clears bit `fp_done_idx` of `sb_fp_pend`. Neither port changes the other vector.
- R4: `stall` is high in any cycle where `iss_valid` is high and an enabled source index names a register pending in either vector.
- R5: `stall` is high when `iss_valid` and `iss_wr_en` are high and the destination is pending in either vector (write after write).
- R6: A register whose only pending bit is being cleared by a completion in the current cycle causes no stall in that cycle.
- R7: When a completion and an accepted issue name the same register in one cycle, the issue's bit is set after the edge. If the completion and the issue concern the same cause, that bit stays set.
- R8: Bit 0 of both vectors is always zero, and index 0 never causes a stall.
- R9: With `iss_valid` low, or with `stall` high, no pending bit is set. With `iss_valid` low, `stall` is low.
- R10: Bit i of each vector reflects register i, and no register is pending in both vectors at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | An instruction is presented for issue |
| iss_kind | input | 2 | 0 integer, 1 load, 2 floating point, 3 integer |
| iss_rd_a_en | input | 1 | First source is read |
| iss_src_a | input | 5 | First source index |
| iss_rd_b_en | input | 1 | Second source is read |
| iss_src_b | input | 5 | Second source index |
| iss_wr_en | input | 1 | Instruction writes a destination |
| iss_dst | input | 5 | Destination index |
| ld_done_valid | input | 1 | Load data returns this cycle |
| ld_done_idx | input | 5 | Register receiving load data |
| fp_done_valid | input | 1 | Floating-point result written this cycle |
| fp_done_idx | input | 5 | Register receiving the floating-point result |
| stall | output | 1 | Hold the presented instruction |
| sb_load_pend | output | 32 | Pending-load bit per register |
| sb_fp_pend | output | 32 | Pending floating-point bit per register |

## Verification
The bench checks a completion and an instruction that meet on the same register in one cycle. A design that ignores the same-cycle completion stalls needlessly. A design that lets clear win over set loses a pending result, and a later reader would get stale data. The bench issues an integer write to a register with a pending floating-point result. A design without the write-after-write check would let the older write land last. It also issues with a stall in force and with valid low, to catch designs that mark registers for instructions that never issued. It targets index 0, which a design must neither mark nor stall on.

// File: rtl/sb_pkg.sv
package sb_pkg;
  localparam int SB_NREGS = 32;
  localparam int SB_IDX_W = $clog2(SB_NREGS);

  typedef enum logic [1:0] {
    KIND_INT  = 2'd0,
    KIND_LOAD = 2'd1,
    KIND_FP   = 2'd2,
    KIND_RSVD = 2'd3
  } op_kind_e;
endpackage

// File: rtl/sb_flag_bank.sv
module sb_flag_bank #(
  parameter int NREGS = 32,
  parameter int IDX_W = $clog2(NREGS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_en,
  input  logic [IDX_W-1:0] set_idx,
  input  logic             clr_en,
  input  logic [IDX_W-1:0] clr_idx,
  output logic [NREGS-1:0] flags
);
  logic [NREGS-1:0] set_mask, clr_mask, flags_nx;

  // one-hot decode, bit 0 excluded from setting
  always_comb begin
    set_mask = '0;
    clr_mask = '0;
    if (set_en && set_idx != '0) set_mask[set_idx] = 1'b1;
    if (clr_en) clr_mask[clr_idx] = 1'b1;
  end

  // set takes priority over a clear of the same bit
  assign flags_nx = ((flags & ~clr_mask) | set_mask) & ~{{(NREGS-1){1'b0}}, 1'b1};

  always_ff @(posedge clk) begin
    if (!rst_n) flags <= '0;
    else        flags <= flags_nx;
  end

  p_zero_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !flags[0]);

  p_mark_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (set_en && set_idx != '0) |=> flags[$past(set_idx)]);

  p_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && !(set_en && set_idx == clr_idx)) |=> !flags[$past(clr_idx)]);
endmodule

// File: rtl/sb_hazard.sv
module sb_hazard #(
  parameter int NREGS = 32,
  parameter int IDX_W = $clog2(NREGS)
) (
  input  logic [NREGS-1:0] busy,
  input  logic             valid,
  input  logic             rd_a_en,
  input  logic [IDX_W-1:0] src_a,
  input  logic             rd_b_en,
  input  logic [IDX_W-1:0] src_b,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] dst,
  output logic             stall
);
  logic [2:0] hit;

  always_comb begin
    hit[0] = rd_a_en && busy[src_a];
    hit[1] = rd_b_en && busy[src_b];
    hit[2] = wr_en   && busy[dst];
    stall  = valid && (|hit);
  end
endmodule

// File: rtl/reg_scoreboard.sv
module reg_scoreboard
  import sb_pkg::*;
#(
  parameter int NREGS = SB_NREGS,
  parameter int IDX_W = $clog2(NREGS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             iss_valid,
  input  logic [1:0]       iss_kind,
  input  logic             iss_rd_a_en,
  input  logic [IDX_W-1:0] iss_src_a,
  input  logic             iss_rd_b_en,
  input  logic [IDX_W-1:0] iss_src_b,
  input  logic             iss_wr_en,
  input  logic [IDX_W-1:0] iss_dst,
  input  logic             ld_done_valid,
  input  logic [IDX_W-1:0] ld_done_idx,
  input  logic             fp_done_valid,
  input  logic [IDX_W-1:0] fp_done_idx,
  output logic             stall,
  output logic [NREGS-1:0] sb_load_pend,
  output logic [NREGS-1:0] sb_fp_pend
);
  op_kind_e         kind;
  logic             accept, set_ld, set_fp;
  logic [NREGS-1:0] ld_clr_mask, fp_clr_mask, busy_eff;

  assign kind   = op_kind_e'(iss_kind);
  assign accept = iss_valid && !stall;
  assign set_ld = accept && iss_wr_en && (kind == KIND_LOAD);
  assign set_fp = accept && iss_wr_en && (kind == KIND_FP);

  // a completion in this cycle already releases its register
  always_comb begin
    ld_clr_mask = '0;
    fp_clr_mask = '0;
    if (ld_done_valid) ld_clr_mask[ld_done_idx] = 1'b1;
    if (fp_done_valid) fp_clr_mask[fp_done_idx] = 1'b1;
    busy_eff = (sb_load_pend & ~ld_clr_mask) | (sb_fp_pend & ~fp_clr_mask);
  end

  sb_flag_bank #(.NREGS(NREGS), .IDX_W(IDX_W)) u_load_bank (
    .clk(clk), .rst_n(rst_n),
    .set_en(set_ld), .set_idx(iss_dst),
    .clr_en(ld_done_valid), .clr_idx(ld_done_idx),
    .flags(sb_load_pend)
  );

  sb_flag_bank #(.NREGS(NREGS), .IDX_W(IDX_W)) u_fp_bank (
    .clk(clk), .rst_n(rst_n),
    .set_en(set_fp), .set_idx(iss_dst),
    .clr_en(fp_done_valid), .clr_idx(fp_done_idx),
    .flags(sb_fp_pend)
  );

  sb_hazard #(.NREGS(NREGS), .IDX_W(IDX_W)) u_hazard (
    .busy(busy_eff), .valid(iss_valid),
    .rd_a_en(iss_rd_a_en), .src_a(iss_src_a),
    .rd_b_en(iss_rd_b_en), .src_b(iss_src_b),
    .wr_en(iss_wr_en), .dst(iss_dst),
    .stall(stall)
  );

  p_single_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (sb_load_pend & sb_fp_pend) == '0);

  p_stall_no_mark_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (stall || !iss_valid) |=>
      ((sb_load_pend & ~$past(sb_load_pend)) == '0) &&
      ((sb_fp_pend & ~$past(sb_fp_pend)) == '0));

  p_idle_no_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !iss_valid |-> !stall);
endmodule

// File: tb/reg_scoreboard_test.sv
module reg_scoreboard_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        iss_valid = 0, iss_rd_a_en = 0, iss_rd_b_en = 0, iss_wr_en = 0;
  logic [1:0]  iss_kind = 0;
  logic [4:0]  iss_src_a = 0, iss_src_b = 0, iss_dst = 0;
  logic        ld_done_valid = 0, fp_done_valid = 0;
  logic [4:0]  ld_done_idx = 0, fp_done_idx = 0;
  logic        stall;
  logic [31:0] sb_load_pend, sb_fp_pend;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  reg_scoreboard uut (
    .clk(clk), .rst_n(rst_n),
    .iss_valid(iss_valid), .iss_kind(iss_kind),
    .iss_rd_a_en(iss_rd_a_en), .iss_src_a(iss_src_a),
    .iss_rd_b_en(iss_rd_b_en), .iss_src_b(iss_src_b),
    .iss_wr_en(iss_wr_en), .iss_dst(iss_dst),
    .ld_done_valid(ld_done_valid), .ld_done_idx(ld_done_idx),
    .fp_done_valid(fp_done_valid), .fp_done_idx(fp_done_idx),
    .stall(stall), .sb_load_pend(sb_load_pend), .sb_fp_pend(sb_fp_pend)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    iss_valid = 0; iss_rd_a_en = 0; iss_rd_b_en = 0; iss_wr_en = 0;
    iss_kind = 0; iss_src_a = 0; iss_src_b = 0; iss_dst = 0;
    ld_done_valid = 0; fp_done_valid = 0; ld_done_idx = 0; fp_done_idx = 0;
  endtask

  task automatic issue(input logic [1:0] k, input logic ra, input logic [4:0] a,
                       input logic rb, input logic [4:0] b,
                       input logic w, input logic [4:0] d);
    iss_valid = 1; iss_kind = k; iss_rd_a_en = ra; iss_src_a = a;
    iss_rd_b_en = rb; iss_src_b = b; iss_wr_en = w; iss_dst = d;
  endtask

  // advance one edge; inputs were set after a falling edge
  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    idle();
    #1;
  endtask

  task automatic t_reset();
    check("R1 load vector", sb_load_pend, 32'h0);
    check("R1 fp vector", sb_fp_pend, 32'h0);
    check("R1 stall", {31'b0, stall}, 32'h0);
  endtask

  task automatic t_mark();
    issue(2'd1, 0, 0, 0, 0, 1, 5'd5); #1;
    check("R2 load accepted", {31'b0, stall}, 32'h0);
    tick();
    check("R2 load marks r5", sb_load_pend, 32'h20);
    issue(2'd2, 0, 0, 0, 0, 1, 5'd7); tick();
    check("R2 fp marks r7", sb_fp_pend, 32'h80);
    check("R10 r5 only in load vector", sb_load_pend, 32'h20);
    issue(2'd0, 0, 0, 0, 0, 1, 5'd9); tick();
    issue(2'd3, 0, 0, 0, 0, 1, 5'd10); tick();
    check("R2 integer marks nothing (load)", sb_load_pend, 32'h20);
    check("R2 integer marks nothing (fp)", sb_fp_pend, 32'h80);
  endtask

  task automatic t_hazard();
    issue(2'd0, 1, 5'd5, 0, 0, 1, 5'd11); #1;
    check("R4 src a pending load", {31'b0, stall}, 32'h1);
    tick();
    check("R9 stalled load vector unchanged", sb_load_pend, 32'h20);
    issue(2'd1, 0, 0, 1, 5'd7, 1, 5'd12); #1;
    check("R4 src b pending fp", {31'b0, stall}, 32'h1);
    tick();
    check("R9 stalled load does not mark r12", sb_load_pend, 32'h20);
    issue(2'd0, 0, 5'd5, 0, 5'd7, 1, 5'd13); #1;
    check("R4 disabled sources ignored", {31'b0, stall}, 32'h0);
    idle(); #1;
    issue(2'd0, 0, 0, 0, 0, 1, 5'd7); #1;
    check("R5 write after write on r7", {31'b0, stall}, 32'h1);
    issue(2'd0, 0, 0, 0, 0, 0, 5'd7); #1;
    check("R5 no write enable no stall", {31'b0, stall}, 32'h0);
    idle(); iss_rd_a_en = 1; iss_src_a = 5'd5; iss_kind = 2'd1;
    iss_wr_en = 1; iss_dst = 5'd14; #1;
    check("R9 valid low no stall", {31'b0, stall}, 32'h0);
    tick();
    check("R9 valid low marks nothing", sb_load_pend, 32'h20);
  endtask

  task automatic t_complete();
    fp_done_valid = 1; fp_done_idx = 5'd7; tick();
    check("R3 fp done clears r7", sb_fp_pend, 32'h0);
    check("R3 fp done leaves load vector", sb_load_pend, 32'h20);
    ld_done_valid = 1; ld_done_idx = 5'd5; tick();
    check("R3 load done clears r5", sb_load_pend, 32'h0);
  endtask

  task automatic t_same_cycle();
    issue(2'd1, 0, 0, 0, 0, 1, 5'd3); tick();
    ld_done_valid = 1; ld_done_idx = 5'd3;
    iss_valid = 1; iss_rd_a_en = 1; iss_src_a = 5'd3; #1;
    check("R6 completing source no stall", {31'b0, stall}, 32'h0);
    tick();
    issue(2'd1, 0, 0, 0, 0, 1, 5'd4); tick();
    issue(2'd1, 0, 0, 0, 0, 1, 5'd4); ld_done_valid = 1; ld_done_idx = 5'd4; #1;
    check("R6 completing destination no stall", {31'b0, stall}, 32'h0);
    tick();
    check("R7 re-issued load keeps r4 set", sb_load_pend, 32'h10);
    issue(2'd2, 0, 0, 0, 0, 1, 5'd4); ld_done_valid = 1; ld_done_idx = 5'd4; tick();
    check("R7 fp set while load clears (load)", sb_load_pend, 32'h0);
    check("R7 fp set while load clears (fp)", sb_fp_pend, 32'h10);
    fp_done_valid = 1; fp_done_idx = 5'd4; tick();
    check("R3 fp cleared r4", sb_fp_pend, 32'h0);
  endtask

  task automatic t_zero();
    issue(2'd1, 0, 0, 0, 0, 1, 5'd0); tick();
    issue(2'd2, 0, 0, 0, 0, 1, 5'd0); tick();
    check("R8 load never marks r0", sb_load_pend, 32'h0);
    check("R8 fp never marks r0", sb_fp_pend, 32'h0);
    issue(2'd0, 1, 5'd0, 1, 5'd0, 1, 5'd0); #1;
    check("R8 r0 never stalls", {31'b0, stall}, 32'h0);
    idle();
  endtask

  task automatic t_reset_again();
    issue(2'd1, 0, 0, 0, 0, 1, 5'd31); tick();
    issue(2'd2, 0, 0, 0, 0, 1, 5'd30); tick();
    check("R10 top register load bit", sb_load_pend, 32'h8000_0000);
    check("R10 r30 fp bit", sb_fp_pend, 32'h4000_0000);
    rst_n = 0; tick(); rst_n = 1; #1;
    check("R1 reset clears load vector", sb_load_pend, 32'h0);
    check("R1 reset clears fp vector", sb_fp_pend, 32'h0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    idle();
    @(negedge clk); @(negedge clk);
    rst_n = 1; #1;
    t_reset();
    t_mark();
    t_hazard();
    t_complete();
    t_same_cycle();
    t_zero();
    t_reset_again();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule